// File: doc/BRIEF.md
# Multi-Mode Operand Address Resolver

This block fetches the source operand of a register-memory arithmetic instruction. A start strobe presents a mode code, a base register value with its index, a second (index) register value, a signed displacement and the address of the instruction. The block works out the operand address for the chosen mode, issues one or two reads on a request/valid memory port, and returns the operand. Two of the modes also produce a new base register value. It also handles the modes that need no memory access.

The sequencer takes new work only when idle. Every memory read holds its request and address until the memory answers with valid. The operand, and any base write-back, are presented with a single-cycle done pulse. The element step used by the auto-update modes and the index scale are parameters. Their default is 4 bytes.

Top module: `eag_operand_fetch`

## Requirements
- R1: After reset, `done`, `mem_req` and `wb_en` are low. They stay low until a start is accepted.
- R2: Mode code 0 (register) returns `base_val` as the operand. It issues no memory request. `done` rises in the cycle right after the start edge.
- R3: Mode code 1 (immediate) returns `disp_val` as the operand, with no memory request and the same one-cycle timing as R2.
- R4: Single-read modes issue one read and return its data. The read address depends on the mode: code 2 reads at base; code 3 at base+disp; code 4 at disp alone; code 5 at base+index; code 7 at pc+disp; code 8 at disp+base+index*4. All sums are modulo 2^32.
- R5: Mode code 6 (memory indirect) reads at base. It then reads again at the word that came back, and returns the second word.
- R6: Mode code 9 (post-increment) reads at base and returns that data. In the done cycle it drives `wb_en`=1, `wb_idx`=`base_idx` and `wb_val`=base+4.
- R7: Mode code 10 (pre-decrement) reads at base-4. It returns that data and, in the done cycle, drives `wb_en`=1, `wb_idx`=`base_idx` and `wb_val`=base-4.
- R8: While `mem_req` is high and `mem_valid` is low, the request and its address hold. `done` rises in the cycle after the valid that ends the final read, and `mem_req` is low while `done` is high.
- R9: `done` is a single-cycle pulse. `wb_en` is high only together with `done`, and only for codes 9 and 10.
- R10: A start seen while an operation is in flight is ignored. Codes 11 to 15 act as register mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch; sampled only when idle |
| mode | input | 4 | Addressing mode code |
| base_val | input | 32 | Base register contents |
| base_idx | input | 5 | Base register number, echoed on write-back |
| index_val | input | 32 | Second register contents |
| disp_val | input | 32 | Sign-extended displacement or constant |
| pc_val | input | 32 | Address of the current instruction |
| mem_req | output | 1 | Read request, held until valid |
| mem_addr | output | 32 | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| operand | output | 32 | Resolved operand, valid with done |
| wb_en | output | 1 | Base write-back enable |
| wb_idx | output | 5 | Base register number to update |
| wb_val | output | 32 | Updated base value |
| done | output | 1 | One-cycle completion pulse |

## Verification
In the auto-update modes, the operand delivery and the base register write-back fall in the same cycle. The bench provokes this with post-increment and pre-decrement fetches under several memory latencies. It judges it by sampling `operand`, `wb_en`, `wb_idx` and `wb_val` together on the single cycle where `done` is high. The bench also checks that neither output leaks into the cycles around it. A second collision is a new start arriving while a fetch is waiting on memory. The bench drives starts during a slow read and checks that only the first operation completes.

// File: rtl/eag_pkg.sv
package eag_pkg;
   typedef enum logic [3:0] {
      AM_REG    = 4'd0,
      AM_IMM    = 4'd1,
      AM_RIND   = 4'd2,
      AM_DISP   = 4'd3,
      AM_ABS    = 4'd4,
      AM_IDX    = 4'd5,
      AM_MIND   = 4'd6,
      AM_PCREL  = 4'd7,
      AM_SCALED = 4'd8,
      AM_POSTI  = 4'd9,
      AM_PRED   = 4'd10
   } amode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ1 = 2'd1,
      ST_READ2 = 2'd2,
      ST_FIN   = 2'd3
   } fstate_e;
endpackage

// File: rtl/eag_addr_gen.sv
module eag_addr_gen #(
   parameter int DATA_W      = 32,
   parameter int ELEM_BYTES  = 4,
   parameter int SCALE_SHIFT = 2
) (
   input  logic [3:0]        mode,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] index_val,
   input  logic [DATA_W-1:0] disp_val,
   input  logic [DATA_W-1:0] pc_val,
   output logic [DATA_W-1:0] rd_addr,
   output logic [DATA_W-1:0] direct_val,
   output logic              needs_mem,
   output logic              two_reads,
   output logic              upd_en,
   output logic [DATA_W-1:0] upd_val
);
   import eag_pkg::*;

   localparam logic [DATA_W-1:0] STEP = DATA_W'(ELEM_BYTES);

   logic [DATA_W-1:0] scaled_idx;

   generate
      if (SCALE_SHIFT == 0) begin : g_noscale
         assign scaled_idx = index_val;
      end else begin : g_scale
         assign scaled_idx = {index_val[DATA_W-1-SCALE_SHIFT:0], {SCALE_SHIFT{1'b0}}};
      end
   endgenerate

   always_comb begin
      rd_addr    = base_val;
      direct_val = base_val;
      needs_mem  = 1'b0;
      two_reads  = 1'b0;
      upd_en     = 1'b0;
      upd_val    = base_val;
      case (mode)
         AM_IMM:    direct_val = disp_val;
         AM_RIND:   needs_mem = 1'b1;
         AM_DISP: begin
            rd_addr   = base_val + disp_val;
            needs_mem = 1'b1;
         end
         AM_ABS: begin
            rd_addr   = disp_val;
            needs_mem = 1'b1;
         end
         AM_IDX: begin
            rd_addr   = base_val + index_val;
            needs_mem = 1'b1;
         end
         AM_MIND: begin
            needs_mem = 1'b1;
            two_reads = 1'b1;
         end
         AM_PCREL: begin
            rd_addr   = pc_val + disp_val;
            needs_mem = 1'b1;
         end
         AM_SCALED: begin
            rd_addr   = disp_val + base_val + scaled_idx;
            needs_mem = 1'b1;
         end
         AM_POSTI: begin
            needs_mem = 1'b1;
            upd_en    = 1'b1;
            upd_val   = base_val + STEP;
         end
         AM_PRED: begin
            rd_addr   = base_val - STEP;
            upd_val   = base_val - STEP;
            needs_mem = 1'b1;
            upd_en    = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/eag_seq.sv
module eag_seq #(
   parameter int DATA_W = 32,
   parameter int RIDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] direct_val,
   input  logic              needs_mem,
   input  logic              two_reads,
   input  logic              upd_en,
   input  logic [DATA_W-1:0] upd_val,
   input  logic [RIDX_W-1:0] base_idx,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] operand,
   output logic              wb_en,
   output logic [RIDX_W-1:0] wb_idx,
   output logic [DATA_W-1:0] wb_val,
   output logic              done
);
   import eag_pkg::*;

   fstate_e           state_q;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] res_q;
   logic              two_q;
   logic              upd_q;
   logic [DATA_W-1:0] upd_val_q;
   logic [RIDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         res_q     <= '0;
         two_q     <= 1'b0;
         upd_q     <= 1'b0;
         upd_val_q <= '0;
         idx_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               addr_q    <= rd_addr;
               two_q     <= two_reads;
               upd_q     <= upd_en;
               upd_val_q <= upd_val;
               idx_q     <= base_idx;
               if (needs_mem) begin
                  state_q <= ST_READ1;
               end else begin
                  res_q   <= direct_val;
                  state_q <= ST_FIN;
               end
            end
            ST_READ1: if (mem_valid) begin
               if (two_q) begin
                  addr_q  <= mem_rdata;
                  state_q <= ST_READ2;
               end else begin
                  res_q   <= mem_rdata;
                  state_q <= ST_FIN;
               end
            end
            ST_READ2: if (mem_valid) begin
               res_q   <= mem_rdata;
               state_q <= ST_FIN;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req  = (state_q == ST_READ1) || (state_q == ST_READ2);
   assign mem_addr = addr_q;
   assign done     = (state_q == ST_FIN);
   assign operand  = res_q;
   assign wb_en    = done && upd_q;
   assign wb_idx   = idx_q;
   assign wb_val   = upd_val_q;
endmodule

// File: rtl/eag_operand_fetch.sv
module eag_operand_fetch #(
   parameter int DATA_W      = 32,
   parameter int RIDX_W      = 5,
   parameter int ELEM_BYTES  = 4,
   parameter int SCALE_SHIFT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        mode,
   input  logic [DATA_W-1:0] base_val,
   input  logic [RIDX_W-1:0] base_idx,
   input  logic [DATA_W-1:0] index_val,
   input  logic [DATA_W-1:0] disp_val,
   input  logic [DATA_W-1:0] pc_val,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] operand,
   output logic              wb_en,
   output logic [RIDX_W-1:0] wb_idx,
   output logic [DATA_W-1:0] wb_val,
   output logic              done
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
      if (SCALE_SHIFT < 0 || SCALE_SHIFT >= DATA_W) begin : g_bad_scale
         $error("SCALE_SHIFT out of range");
      end
      if (ELEM_BYTES < 1) begin : g_bad_elem
         $error("ELEM_BYTES must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] ag_addr;
   logic [DATA_W-1:0] ag_direct;
   logic              ag_mem;
   logic              ag_two;
   logic              ag_upd;
   logic [DATA_W-1:0] ag_upd_val;

   eag_addr_gen #(
      .DATA_W(DATA_W), .ELEM_BYTES(ELEM_BYTES), .SCALE_SHIFT(SCALE_SHIFT)
   ) u_agen (
      .mode(mode), .base_val(base_val), .index_val(index_val),
      .disp_val(disp_val), .pc_val(pc_val), .rd_addr(ag_addr),
      .direct_val(ag_direct), .needs_mem(ag_mem), .two_reads(ag_two),
      .upd_en(ag_upd), .upd_val(ag_upd_val)
   );

   eag_seq #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(ag_addr),
      .direct_val(ag_direct), .needs_mem(ag_mem), .two_reads(ag_two),
      .upd_en(ag_upd), .upd_val(ag_upd_val), .base_idx(base_idx),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .operand(operand), .wb_en(wb_en),
      .wb_idx(wb_idx), .wb_val(wb_val), .done(done)
   );
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_valid,
   input logic [DATA_W-1:0] mem_addr,
   input logic              done,
   input logic              wb_en
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R8
   AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req); // R8
   AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && $past(mem_req)) |-> $past(mem_valid)); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done); // R6
endmodule

bind eag_operand_fetch eag_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_valid(mem_valid),
   .mem_addr(mem_addr), .done(done), .wb_en(wb_en)
);

// File: tb/tb_eag_operand_fetch.sv
`timescale 1ns/1ps
module tb_eag_operand_fetch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [31:0] base_val = '0;
   logic [4:0]  base_idx = '0;
   logic [31:0] index_val = '0;
   logic [31:0] disp_val = '0;
   logic [31:0] pc_val = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [31:0] operand;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [31:0] wb_val;
   logic        done;

   int checks = 0;
   int failures = 0;
   int lat = 0;
   int mcnt = 0;
   int rd_cnt = 0;
   logic [31:0] rd_log [4];
   bit finished = 0;

   always #2 clk = ~clk;

   eag_operand_fetch dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .base_val(base_val), .base_idx(base_idx), .index_val(index_val),
      .disp_val(disp_val), .pc_val(pc_val), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .operand(operand), .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
      .done(done)
   );

   function automatic logic [31:0] memf(input logic [31:0] a);
      return a ^ 32'h5A5A_0F0F;
   endfunction

   // memory model: valid one cycle, after lat wait cycles
   always @(posedge clk) begin
      if (mem_valid) begin
         mem_valid <= 1'b0;
         mcnt <= 0;
      end else if (mem_req) begin
         if (mcnt >= lat) begin
            mem_valid <= 1'b1;
            mem_rdata <= memf(mem_addr);
         end else mcnt <= mcnt + 1;
      end else mcnt <= 0;
   end

   always @(negedge clk) begin
      if (mem_req && mem_valid) begin
         if (rd_cnt < 4) rd_log[rd_cnt] <= mem_addr;
         rd_cnt <= rd_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic string req_of(input logic [3:0] m);
      case (m)
         4'd0: return "R2";
         4'd1: return "R3";
         4'd6: return "R5";
         4'd9: return "R6";
         4'd10: return "R7";
         default: return (m > 4'd10) ? "R10" : "R4";
      endcase
   endfunction

   typedef struct packed {
      logic [3:0]  m;
      logic [31:0] base;
      logic [31:0] idx;
      logic [31:0] disp;
      logic [31:0] pc;
      logic [3:0]  lat;
      logic [31:0] exp;   // first read address, or direct result when nrd==0
      logic [1:0]  nrd;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{4'd0,  32'h0000_1234, 32'h5, 32'h99,        32'h0,   4'd0, 32'h0000_1234, 2'd0}, // R2
      '{4'd1,  32'h0000_1234, 32'h5, 32'hFFFF_FFF0, 32'h0,   4'd0, 32'hFFFF_FFF0, 2'd0}, // R3
      '{4'd2,  32'h0000_0100, 32'h0, 32'h0,         32'h0,   4'd1, 32'h0000_0100, 2'd1}, // R4
      '{4'd3,  32'h0000_0100, 32'h0, 32'h4,         32'h0,   4'd0, 32'h0000_0104, 2'd1}, // R4
      '{4'd3,  32'h0000_0200, 32'h0, 32'hFFFF_FFF8, 32'h0,   4'd2, 32'h0000_01F8, 2'd1}, // R4
      '{4'd4,  32'h0000_0999, 32'h0, 32'h475,       32'h0,   4'd0, 32'h0000_0475, 2'd1}, // R4
      '{4'd5,  32'h0000_0100, 32'h8, 32'h0,         32'h0,   4'd0, 32'h0000_0108, 2'd1}, // R4
      '{4'd7,  32'h0000_0000, 32'h0, 32'hFFFF_FFF0, 32'h116, 4'd1, 32'h0000_0106, 2'd1}, // R4
      '{4'd8,  32'h0000_0040, 32'h3, 32'h64,        32'h0,   4'd0, 32'h0000_00B0, 2'd1}, // R4
      '{4'd6,  32'h0000_0104, 32'h0, 32'h0,         32'h0,   4'd1, 32'h0000_0104, 2'd2}, // R5
      '{4'd6,  32'h0000_0040, 32'h0, 32'h0,         32'h0,   4'd0, 32'h0000_0040, 2'd2}, // R5
      '{4'd9,  32'h0000_0100, 32'h0, 32'h0,         32'h0,   4'd0, 32'h0000_0100, 2'd1}, // R6
      '{4'd10, 32'h0000_0100, 32'h0, 32'h0,         32'h0,   4'd2, 32'h0000_00FC, 2'd1}, // R7
      '{4'd13, 32'h0000_0077, 32'h1, 32'h2,         32'h3,   4'd0, 32'h0000_0077, 2'd0}  // R10
   };

   task automatic wait_done(output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!done && cyc < 100);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!done && !mem_req && !wb_en, "R1", {29'd0, done, mem_req, wb_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !mem_req && !wb_en, "R1", {29'd0, done, mem_req, wb_en}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         vec_t v = VEC[i];
         logic [31:0] exp_op;
         int exp_cyc;
         bit exp_wb;
         logic [31:0] exp_wbv;
         string rq = req_of(v.m);
         lat = int'(v.lat);
         rd_cnt = 0;
         mode = v.m; base_val = v.base; index_val = v.idx;
         disp_val = v.disp; pc_val = v.pc; base_idx = 5'(i + 3);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         cyc = 1;
         while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
         end
         case (v.nrd)
            2'd0: begin exp_op = v.exp; exp_cyc = 1; end
            2'd1: begin exp_op = memf(v.exp); exp_cyc = 3 + lat; end
            default: begin exp_op = memf(memf(v.exp)); exp_cyc = 5 + 2 * lat; end
         endcase
         exp_wb  = (v.m == 4'd9) || (v.m == 4'd10);
         exp_wbv = (v.m == 4'd9) ? v.base + 32'd4 : v.base - 32'd4;
         chk(done == 1'b1, rq, {31'd0, done}, 32'd1);
         chk(operand == exp_op, rq, operand, exp_op);
         chk(cyc == exp_cyc, "R8", cyc, exp_cyc);       // R8 completion timing
         chk(rd_cnt == int'(v.nrd), rq, rd_cnt, {30'd0, v.nrd});
         if (v.nrd != 0) chk(rd_log[0] == v.exp, rq, rd_log[0], v.exp);
         if (v.nrd == 2) chk(rd_log[1] == memf(v.exp), "R5", rd_log[1], memf(v.exp));
         chk(wb_en == exp_wb, "R9", {31'd0, wb_en}, {31'd0, exp_wb});
         if (exp_wb) begin
            chk(wb_val == exp_wbv, rq, wb_val, exp_wbv);
            chk(wb_idx == 5'(i + 3), rq, {27'd0, wb_idx}, 32'(i + 3));
         end
         @(negedge clk);
         chk(!done && !wb_en, "R9", {30'd0, done, wb_en}, 32'd0);
      end

      // R10: starts while a post-increment read waits are ignored
      lat = 3;
      rd_cnt = 0;
      mode = 4'd9; base_val = 32'h200; base_idx = 5'd7;
      start = 1'b1;
      @(negedge clk);
      mode = 4'd0; base_val = 32'h999; base_idx = 5'd1;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc);
      chk(operand == memf(32'h200), "R10", operand, memf(32'h200));
      chk(wb_val == 32'h204 && wb_idx == 5'd7, "R10", wb_val, 32'h204);
      chk(rd_cnt == 1 && rd_log[0] == 32'h200, "R10", rd_log[0], 32'h200);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(!done && !mem_req, "R10", {30'd0, done, mem_req}, 32'd0);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule